// File: doc/BRIEF.md
# Ethernet Link Mode Selector

This block settles the operating mode of a 10/100 Ethernet PHY. While reset is held it decodes three strap pins (one enable strap and two mode straps). The result is either a fixed speed and duplex or a set of modes to offer the link partner. The strap values are loaded into a control register and an ability-offer register. After reset, only register writes change these registers.

Software reaches four registers through a simple port with address, write strobe, write data and combinational read data. With autonegotiation on, the block intersects its offered modes with the partner's ability word and picks the best shared mode. With autonegotiation off, it drives the speed and duplex taken from the control register. The resolved speed, duplex and a valid flag are registered outputs. They follow their inputs one clock later.

Top module: `lnk_mode_sel`

## Requirements
- R1: With the enable strap at 0 during reset, mode straps 00/01/10/11 give 10 half, 10 full, 100 half and 100 full. The control register (address 0x00) then reads speed in bit 13 = mode[1] and duplex in bit 8 = mode[0], with enable bit 12 = 0. Outputs `spd_100_o`/`full_dup_o` follow with `mode_vld_o` = 1, and all four offer bits are set.
- R2: With the enable strap at 1 during reset, the control register reads 0x3100. The offer register (address 0x04) holds ability bits [8:5]: bit 8 is 100 full, bit 7 is 100 half, bit 6 is 10 full and bit 5 is 10 half. Bits [4:0] read 00001. Mode straps 00/01/10/11 set the ability bits to 0011, 1100, 0101 and 1111.
- R3: Strap changes after reset has been released have no effect on any register or output.
- R4: With autonegotiation on, the chosen mode is the highest shared bit of offer[8:5] AND partner[8:5]. The order is 100 full, then 100 half, then 10 full, then 10 half. The result appears on the outputs one clock after its inputs.
- R5: With autonegotiation on and no shared mode, `mode_vld_o` is 0, both speed and duplex outputs are 0, and the negotiation-complete flag is 0. With a shared mode, the complete flag is 1.
- R6: A write to address 0x00 replaces the reset-time mode. With bit 12 clear, bit 13 sets 100 Mb/s and bit 8 sets full duplex, and `mode_vld_o` is 1 with the complete flag 0.
- R7: While bit 12 of the control register is set, bits 13 and 8 have no effect on the outputs.
- R8: Writing bit 9 of the control register starts a restart. On the next clock, bit 9 reads 1. One clock later, the valid output and the complete flag are 0 and bit 9 reads 0. One further clock later, the resolution is back in effect.
- R9: The status register at 0x01 reads 0x7849 plus three variable bits. Bit 5 is negotiation complete. Bit 4 is the partner's remote-fault bit (partner word bit 13). Bit 2 is set when `link_ok_i` and `mode_vld_o` are both 1. The 100BASE-T4 bit 15 reads 0.
- R10: The PHY status register at 0x10 has four bits. Bit 0 is link valid (`link_ok_i` AND `mode_vld_o`). Bit 1 is set when link is valid at 10 Mb/s. Bit 2 is set when link is valid at full duplex. Bit 4 is negotiation complete.
- R11: Other addresses read 0, and writes to them leave every register and output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are loaded while it is low |
| strap_aneg_i | input | 1 | Enable strap: 1 selects autonegotiation |
| strap_mode_i | input | 2 | Mode straps |
| partner_word_i | input | 16 | Partner ability word: [8:5] abilities, [13] remote fault |
| link_ok_i | input | 1 | Line-side link indication |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data (combinational) |
| spd_100_o | output | 1 | Resolved speed, 1 = 100 Mb/s |
| full_dup_o | output | 1 | Resolved duplex, 1 = full |
| mode_vld_o | output | 1 | Resolved mode is valid |

## Verification
Several properties are checked on every clock by assertions. The restart bit self-clears. A restart blanks the valid output and the complete flag. An empty intersection holds the valid output low. Forced mode follows the control bits one clock later. The priority pick is never more than one-hot. Other behaviour is shown only by the bench's scenarios: the strap decode table, the fact that straps are ignored after reset, the exact priority choice for each pattern of offer and partner bits, and the register read values.

// File: rtl/lnk_mode_pkg.sv
package lnk_mode_pkg;
    localparam int NMODE  = 4;
    localparam int DATA_W = 16;

    localparam int A_CTRL = 'h00;
    localparam int A_STAT = 'h01;
    localparam int A_ADV  = 'h04;
    localparam int A_PSTS = 'h10;

    localparam int B_SPD  = 13;
    localparam int B_ANEG = 12;
    localparam int B_RST  = 9;
    localparam int B_FDX  = 8;
    localparam int B_ABLO = 5;

    localparam logic [DATA_W-1:0] STAT_FIXED = 16'h7849;
    localparam logic [4:0]        ADV_SEL    = 5'b00001;

    typedef struct packed {
        logic spd100;
        logic aneg;
        logic restart;
        logic fdx;
    } ctrl_t;

    typedef struct packed {
        logic vld;
        logic spd100;
        logic fdx;
        logic done;
    } res_t;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [NMODE-1:0] adv;
        res_t             res;
    } state_t;
endpackage

// File: rtl/lnk_strap_dec.sv
module lnk_strap_dec
    import lnk_mode_pkg::*;
(
    input  logic             aneg_i,
    input  logic [1:0]       mode_i,
    output ctrl_t            ctrl_o,
    output logic [NMODE-1:0] adv_o
);
    always_comb begin
        ctrl_o         = '0;
        ctrl_o.aneg    = aneg_i;
        ctrl_o.restart = 1'b0;
        adv_o          = '1;
        if (aneg_i) begin
            ctrl_o.spd100 = 1'b1;
            ctrl_o.fdx    = 1'b1;
            unique case (mode_i)
                2'b00:   adv_o = 4'b0011;
                2'b01:   adv_o = 4'b1100;
                2'b10:   adv_o = 4'b0101;
                default: adv_o = 4'b1111;
            endcase
        end else begin
            ctrl_o.spd100 = mode_i[1];
            ctrl_o.fdx    = mode_i[0];
        end
    end
endmodule

// File: rtl/lnk_prio_pick.sv
module lnk_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] common_i,
    output logic [N-1:0] pick_o,
    output logic         any_o
);
    always_comb begin
        pick_o = '0;
        for (int i = 0; i < N; i++) begin
            if (common_i[i]) begin
                pick_o    = '0;
                pick_o[i] = 1'b1;
            end
        end
        any_o = |common_i;
        p_pick_onehot_r4: assert ($onehot0(pick_o));
    end
endmodule

// File: rtl/lnk_mode_sel.sv
module lnk_mode_sel
    import lnk_mode_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_aneg_i,
    input  logic [1:0]        strap_mode_i,
    input  logic [15:0]       partner_word_i,
    input  logic              link_ok_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic              spd_100_o,
    output logic              full_dup_o,
    output logic              mode_vld_o
);
    state_t           st_d, st_q;
    ctrl_t            strap_ctrl;
    logic [NMODE-1:0] strap_adv;
    logic [NMODE-1:0] common, pick;
    logic             any_common;
    logic             link_good;

    lnk_strap_dec u_strap (
        .aneg_i (strap_aneg_i),
        .mode_i (strap_mode_i),
        .ctrl_o (strap_ctrl),
        .adv_o  (strap_adv)
    );

    assign common = st_q.adv & partner_word_i[B_ABLO +: NMODE];

    lnk_prio_pick #(.N(NMODE)) u_pick (
        .common_i (common),
        .pick_o   (pick),
        .any_o    (any_common)
    );

    always_comb begin
        st_d              = st_q;
        st_d.ctrl.restart = 1'b0;
        if (st_q.ctrl.restart) begin
            st_d.res = '0;
        end else if (st_q.ctrl.aneg) begin
            st_d.res.vld    = any_common;
            st_d.res.spd100 = pick[3] | pick[2];
            st_d.res.fdx    = pick[3] | pick[1];
            st_d.res.done   = any_common;
        end else begin
            st_d.res.vld    = 1'b1;
            st_d.res.spd100 = st_q.ctrl.spd100;
            st_d.res.fdx    = st_q.ctrl.fdx;
            st_d.res.done   = 1'b0;
        end
        if (reg_wr_i) begin
            if (int'(reg_addr_i) == A_CTRL) begin
                st_d.ctrl.spd100  = reg_wdata_i[B_SPD];
                st_d.ctrl.aneg    = reg_wdata_i[B_ANEG];
                st_d.ctrl.restart = reg_wdata_i[B_RST];
                st_d.ctrl.fdx     = reg_wdata_i[B_FDX];
            end else if (int'(reg_addr_i) == A_ADV) begin
                st_d.adv = reg_wdata_i[B_ABLO +: NMODE];
            end
        end
        if (!rst_n) begin
            st_d.ctrl = strap_ctrl;
            st_d.adv  = strap_adv;
            st_d.res  = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign spd_100_o  = st_q.res.spd100;
    assign full_dup_o = st_q.res.fdx;
    assign mode_vld_o = st_q.res.vld;
    assign link_good  = link_ok_i & st_q.res.vld;

    always_comb begin
        reg_rdata_o = '0;
        case (int'(reg_addr_i))
            A_CTRL: begin
                reg_rdata_o[B_SPD]  = st_q.ctrl.spd100;
                reg_rdata_o[B_ANEG] = st_q.ctrl.aneg;
                reg_rdata_o[B_RST]  = st_q.ctrl.restart;
                reg_rdata_o[B_FDX]  = st_q.ctrl.fdx;
            end
            A_STAT: begin
                reg_rdata_o    = STAT_FIXED;
                reg_rdata_o[5] = st_q.res.done;
                reg_rdata_o[4] = partner_word_i[13];
                reg_rdata_o[2] = link_good;
            end
            A_ADV: begin
                reg_rdata_o[4:0]             = ADV_SEL;
                reg_rdata_o[B_ABLO +: NMODE] = st_q.adv;
            end
            A_PSTS: begin
                reg_rdata_o[0] = link_good;
                reg_rdata_o[1] = link_good & ~st_q.res.spd100;
                reg_rdata_o[2] = link_good & st_q.res.fdx;
                reg_rdata_o[4] = st_q.res.done;
            end
            default: reg_rdata_o = '0;
        endcase
    end

    p_restart_selfclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.restart && !reg_wr_i) |=> !st_q.ctrl.restart);

    p_restart_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.restart |=> (!mode_vld_o && !st_q.res.done));

    p_no_common_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.aneg && !st_q.ctrl.restart &&
         ((st_q.adv & partner_word_i[8:5]) == '0)) |=> (!mode_vld_o && !st_q.res.done));

    p_forced_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.aneg && !st_q.ctrl.restart) |=>
        (mode_vld_o && spd_100_o == $past(st_q.ctrl.spd100) &&
         full_dup_o == $past(st_q.ctrl.fdx)));
endmodule

// File: tb/lnk_mode_sel_bench.sv
module lnk_mode_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_aneg = 1'b0;
    logic [1:0]  strap_mode = 2'b00;
    logic [15:0] partner = 16'h0001;
    logic        link_ok = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        spd, fdx, vld;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done_flag = 1'b0;

    always #2.5 clk = ~clk;

    lnk_mode_sel u_lnk_mode_sel (
        .clk(clk), .rst_n(rst_n), .strap_aneg_i(strap_aneg), .strap_mode_i(strap_mode),
        .partner_word_i(partner), .link_ok_i(link_ok), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .spd_100_o(spd), .full_dup_o(fdx), .mode_vld_o(vld));

    // {offer[3:0], partner[3:0], vld, spd, fdx}
    localparam logic [10:0] VEC [8] = '{
        {4'b1111, 4'b1111, 3'b111},
        {4'b1111, 4'b0111, 3'b110},
        {4'b1111, 4'b0011, 3'b101},
        {4'b1111, 4'b0001, 3'b100},
        {4'b0101, 4'b0011, 3'b100},
        {4'b0011, 4'b1100, 3'b000},
        {4'b1100, 4'b0110, 3'b110},
        {4'b0110, 4'b1011, 3'b101}
    };

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(logic [4:0] a, output logic [15:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic do_reset(logic an, logic [1:0] m);
        @(negedge clk);
        strap_aneg = an; strap_mode = m; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [15:0] pword(logic [3:0] nib, logic rf);
        return {2'b00, rf, 4'b0000, nib, 5'b00001};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] r;
        logic [3:0]  aneg_adv [4];
        aneg_adv[0] = 4'b0011; aneg_adv[1] = 4'b1100;
        aneg_adv[2] = 4'b0101; aneg_adv[3] = 4'b1111;

        // Vector table: offer/partner priority resolution (R4, R5)
        do_reset(1'b1, 2'b11);
        for (int i = 0; i < 8; i++) begin
            partner = pword(VEC[i][6:3], 1'b0);
            wr_reg(5'h04, {7'b0, VEC[i][10:7], 5'b00001});
            repeat (2) @(negedge clk);
            chk(VEC[i][2] ? "R4 outputs" : "R5 no common",
                {13'b0, vld, spd, fdx}, {13'b0, VEC[i][2:0]});
            rd_reg(5'h01, r);
            chk("R5 complete flag", {15'b0, r[5]}, {15'b0, VEC[i][2]});
        end

        // R1: forced straps
        partner = pword(4'b1111, 1'b0);
        for (int m = 0; m < 4; m++) begin
            do_reset(1'b0, 2'(m));
            rd_reg(5'h00, r);
            chk("R1 ctrl", r, {2'b00, 1'(m >> 1), 4'b0000, 1'(m & 1), 8'h00});
            rd_reg(5'h04, r);
            chk("R1 offer", r, 16'h01E1);
            chk("R1 outputs", {13'b0, vld, spd, fdx}, {13'b0, 1'b1, 1'(m >> 1), 1'(m & 1)});
        end

        // R2: autonegotiation straps
        for (int m = 0; m < 4; m++) begin
            do_reset(1'b1, 2'(m));
            rd_reg(5'h00, r);
            chk("R2 ctrl", r, 16'h3100);
            rd_reg(5'h04, r);
            chk("R2 offer", r, {7'b0, aneg_adv[m], 5'b00001});
        end

        // R3: straps ignored after reset
        do_reset(1'b1, 2'b11);
        strap_aneg = 1'b0; strap_mode = 2'b00;
        repeat (4) @(negedge clk);
        rd_reg(5'h04, r);
        chk("R3 offer kept", r, 16'h01E1);
        rd_reg(5'h00, r);
        chk("R3 ctrl kept", r, 16'h3100);
        chk("R3 outputs kept", {13'b0, vld, spd, fdx}, 16'h0007);

        // R7: speed/duplex bits ignored under autonegotiation
        partner = pword(4'b0001, 1'b0);
        wr_reg(5'h00, 16'h3100);
        repeat (2) @(negedge clk);
        chk("R7 ignored set", {13'b0, vld, spd, fdx}, 16'h0004);
        wr_reg(5'h00, 16'h1000);
        repeat (2) @(negedge clk);
        chk("R7 ignored clear", {13'b0, vld, spd, fdx}, 16'h0004);

        // R6: forced mode by write
        wr_reg(5'h00, 16'h2000);
        @(negedge clk);
        chk("R6 forced 100 half", {13'b0, vld, spd, fdx}, 16'h0006);
        rd_reg(5'h01, r);
        chk("R6 no complete", {15'b0, r[5]}, 16'h0000);
        wr_reg(5'h00, 16'h0100);
        @(negedge clk);
        chk("R6 forced 10 full", {13'b0, vld, spd, fdx}, 16'h0005);

        // R8: restart
        partner = pword(4'b0010, 1'b0);
        wr_reg(5'h00, 16'h1000);
        repeat (2) @(negedge clk);
        chk("R8 pre", {13'b0, vld, spd, fdx}, 16'h0005);
        wr_reg(5'h00, 16'h1200);
        rd_reg(5'h00, r);
        chk("R8 bit reads set", r, 16'h1200);
        chk("R8 old mode held", {15'b0, vld}, 16'h0001);
        @(negedge clk);
        chk("R8 blanked", {13'b0, vld, spd, fdx}, 16'h0000);
        rd_reg(5'h01, r);
        chk("R8 complete cleared", {15'b0, r[5]}, 16'h0000);
        rd_reg(5'h00, r);
        chk("R8 self-clear", r, 16'h1000);
        @(negedge clk);
        chk("R8 resolved again", {13'b0, vld, spd, fdx}, 16'h0005);

        // R9 / R10: status registers
        link_ok = 1'b1;
        partner = pword(4'b0010, 1'b1);
        #0.5;
        rd_reg(5'h01, r);
        chk("R9 status link", r, 16'h787D);
        rd_reg(5'h10, r);
        chk("R10 phy status link", r, 16'h0017);
        link_ok = 1'b0;
        rd_reg(5'h10, r);
        chk("R10 phy status no link", r, 16'h0010);
        partner = pword(4'b0010, 1'b0);
        wr_reg(5'h00, 16'h2100);
        @(negedge clk);
        rd_reg(5'h01, r);
        chk("R9 status forced", r, 16'h7849);

        // R11: unmapped address
        rd_reg(5'h07, r);
        chk("R11 read zero", r, 16'h0000);
        wr_reg(5'h07, 16'hFFFF);
        repeat (2) @(negedge clk);
        chk("R11 outputs unchanged", {13'b0, vld, spd, fdx}, 16'h0007);
        rd_reg(5'h00, r);
        chk("R11 ctrl unchanged", r, 16'h2100);
        rd_reg(5'h04, r);
        chk("R11 offer unchanged", r, 16'h01E1);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule